// File: doc/BRIEF.md
# Interrupt Context Save Sequencer

When an interrupt is accepted, this block pushes the minimum processor context onto a byte-wide stack. A one-cycle start strobe captures a 20-bit program counter, a 16-bit flag word whose top four bits hold the interrupt priority level, and the stack pointer to use. Over the next four cycles the block issues four single-byte writes into the 32-bit window just below that pointer. In the cycle after the last write it reports done and hands back the lowered pointer so the core can update its register.

Two fields share one stored byte: the priority level and the upper four program-counter bits. The flag/PC-high half is written before the PC low half, so the write order does not follow the address order. The pointer is chosen once, at start. The user pointer applies only to software interrupts numbered 32 to 63 that request it. Every other interrupt uses the interrupt pointer.

Top module: `ctx_save_seq`

## Requirements
- R1: While reset is held, and until the first start after it, `mem_we_o`, `done_o`, `sp_wr_o` and `busy_o` are low.
- R2: In the cycle after an accepted start, one write puts flag bits 7:0 at address SP-2. SP is the selected pointer captured at start.
- R3: The second write goes to SP-1. Its byte carries the priority field (flag bits 15:12) in bits 7:4 and PC bits 19:16 in bits 3:0.
- R4: The third write puts PC bits 7:0 at SP-4. The fourth write puts PC bits 15:8 at SP-3.
- R5: The four writes take four consecutive cycles, one byte per cycle. `mem_we_o` is high in exactly those cycles.
- R6: `done_o` and `sp_wr_o` are high for exactly the one cycle after the fourth write. In that cycle `sp_new_o` equals SP-4 and `sp_sel_o` is 1 if the user pointer was used, else 0.
- R7: The user pointer is selected only when `sw_int_i` is 1, `int_num_i` is at least 32, and `u_sel_i` is 1. In every other case the interrupt pointer is selected.
- R8: A start strobe that arrives while a save is running, including its done cycle, is ignored. The running save continues unchanged, and no write follows its done cycle.
- R9: Address arithmetic wraps modulo 2^16. With SP = 0x0002 the addresses are 0x0000, 0x0001, 0xFFFE, 0xFFFF and the new pointer is 0xFFFE.
- R10: Flag bits 11:8 are not stored. Changing them changes no written byte.
- R11: All inputs are sampled at the accepted start. Changes to them during the save do not alter any write or the new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to save context |
| pc_i | input | 20 | Program counter to save |
| flg_i | input | 16 | Flag word; bits 15:12 are the priority level |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| sw_int_i | input | 1 | 1 when the request is a software interrupt |
| int_num_i | input | 6 | Software interrupt number |
| u_sel_i | input | 1 | Stack select flag (1 = user pointer requested) |
| mem_addr_o | output | 16 | Byte write address |
| mem_wdata_o | output | 8 | Byte write data |
| mem_we_o | output | 1 | Write enable, one pulse per byte |
| busy_o | output | 1 | High from the first write through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| sp_wr_o | output | 1 | Stack pointer write-back strobe |
| sp_sel_o | output | 1 | Pointer to update: 1 user, 0 interrupt |
| sp_new_o | output | 16 | Updated stack pointer value |

## Verification
The write port has no back-pressure. The assertions therefore assume the stack memory takes a byte in every cycle that `mem_we_o` is high, and they treat the start strobe as the only event that moves the sequencer out of idle. The bench drives every input on the falling edge and samples outputs there too. It never stalls the write stream. It deliberately raises start and changes the data inputs during a save so that the ignore and hold rules are exercised without breaking those assumptions.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

  localparam int unsigned NSLOT  = 4;
  localparam int unsigned SLOT_W = $clog2(NSLOT);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W0   = 3'd1,
    ST_W1   = 3'd2,
    ST_W2   = 3'd3,
    ST_W3   = 3'd4,
    ST_DONE = 3'd5
  } save_state_e;

  // Distance below the entry pointer for each write slot, in write order.
  function automatic int unsigned slot_offset(input int unsigned slot);
    case (slot)
      0:       return 2;
      1:       return 1;
      2:       return 4;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/ctx_sp_select.sv
module ctx_sp_select #(
  parameter int unsigned SP_W   = 16,
  parameter int unsigned NUM_W  = 6,
  parameter int unsigned USR_LO = 32
) (
  input  logic [SP_W-1:0]  isp_i,
  input  logic [SP_W-1:0]  usp_i,
  input  logic             sw_int_i,
  input  logic [NUM_W-1:0] int_num_i,
  input  logic             u_sel_i,
  output logic [SP_W-1:0]  sp_o,
  output logic             use_usp_o
);

  localparam logic [NUM_W-1:0] LO = NUM_W'(USR_LO);

  always_comb begin
    use_usp_o = sw_int_i && u_sel_i && (int_num_i >= LO);
    sp_o      = use_usp_o ? usp_i : isp_i;
  end

endmodule

// File: rtl/ctx_byte_lane.sv
module ctx_byte_lane
  import ctx_save_pkg::*;
#(
  parameter int unsigned PC_W  = 20,
  parameter int unsigned SP_W  = 16,
  parameter int unsigned IPL_W = 4
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [7:0]        flg_lo_i,
  input  logic [IPL_W-1:0]  ipl_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SP_W-1:0]   addr_o,
  output logic [7:0]        data_o
);

  localparam int unsigned HI_W = PC_W - 16;

  logic [7:0]      byte_c [NSLOT];
  logic [SP_W-1:0] addr_c [NSLOT];

  assign byte_c[0] = flg_lo_i;
  assign byte_c[1] = {ipl_i, pc_i[PC_W-1 -: HI_W]};
  assign byte_c[2] = pc_i[7:0];
  assign byte_c[3] = pc_i[15:8];

  for (genvar g = 0; g < NSLOT; g++) begin : g_addr
    assign addr_c[g] = sp_i - SP_W'(slot_offset(g));
  end

  assign addr_o = addr_c[slot_i];
  assign data_o = byte_c[slot_i];

endmodule

// File: rtl/ctx_save_fsm.sv
module ctx_save_fsm
  import ctx_save_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              accept_o,
  output logic              we_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o
);

  save_state_e state_q, state_d;

  always_comb begin
    accept_o = (state_q == ST_IDLE) && start_i;
    state_d  = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_W0;
      ST_W0:   state_d = ST_W1;
      ST_W1:   state_d = ST_W2;
      ST_W2:   state_d = ST_W3;
      ST_W3:   state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    we_o   = 1'b0;
    slot_o = '0;
    case (state_q)
      ST_W0: begin we_o = 1'b1; slot_o = SLOT_W'(0); end
      ST_W1: begin we_o = 1'b1; slot_o = SLOT_W'(1); end
      ST_W2: begin we_o = 1'b1; slot_o = SLOT_W'(2); end
      ST_W3: begin we_o = 1'b1; slot_o = SLOT_W'(3); end
      default: ;
    endcase
    done_o = (state_q == ST_DONE);
    busy_o = (state_q != ST_IDLE);
  end

  // R8: the done cycle always returns to idle, whatever start does
  a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  // R5: after the first write, the second follows at once
  a_r5_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_W0) |=> we_o);

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
  import ctx_save_pkg::*;
#(
  parameter int unsigned PC_W   = 20,
  parameter int unsigned FLG_W  = 16,
  parameter int unsigned SP_W   = 16,
  parameter int unsigned IPL_W  = 4,
  parameter int unsigned NUM_W  = 6,
  parameter int unsigned USR_LO = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [FLG_W-1:0] flg_i,
  input  logic [SP_W-1:0]  isp_i,
  input  logic [SP_W-1:0]  usp_i,
  input  logic             sw_int_i,
  input  logic [NUM_W-1:0] int_num_i,
  input  logic             u_sel_i,
  output logic [SP_W-1:0]  mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             mem_we_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sp_wr_o,
  output logic             sp_sel_o,
  output logic [SP_W-1:0]  sp_new_o
);

  localparam logic [SP_W-1:0] FRAME = SP_W'(NSLOT);

  logic              accept;
  logic [SLOT_W-1:0] slot;
  logic [SP_W-1:0]   sp_pick;
  logic              use_usp;

  logic [PC_W-1:0]   pc_q;
  logic [7:0]        flg_lo_q;
  logic [IPL_W-1:0]  ipl_q;
  logic [SP_W-1:0]   sp_q;
  logic              usp_q;

  // flag bits between the low byte and the priority field are not kept
  logic unused_flg_mid;
  assign unused_flg_mid = ^flg_i[FLG_W-IPL_W-1:8];

  ctx_sp_select #(.SP_W(SP_W), .NUM_W(NUM_W), .USR_LO(USR_LO)) u_sel (
    .isp_i     (isp_i),
    .usp_i     (usp_i),
    .sw_int_i  (sw_int_i),
    .int_num_i (int_num_i),
    .u_sel_i   (u_sel_i),
    .sp_o      (sp_pick),
    .use_usp_o (use_usp)
  );

  ctx_save_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .we_o     (mem_we_o),
    .done_o   (done_o),
    .busy_o   (busy_o),
    .slot_o   (slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      flg_lo_q <= '0;
      ipl_q    <= '0;
      sp_q     <= '0;
      usp_q    <= 1'b0;
    end else if (accept) begin
      pc_q     <= pc_i;
      flg_lo_q <= flg_i[7:0];
      ipl_q    <= flg_i[FLG_W-1 -: IPL_W];
      sp_q     <= sp_pick;
      usp_q    <= use_usp;
    end
  end

  ctx_byte_lane #(.PC_W(PC_W), .SP_W(SP_W), .IPL_W(IPL_W)) u_lane (
    .pc_i     (pc_q),
    .flg_lo_i (flg_lo_q),
    .ipl_i    (ipl_q),
    .sp_i     (sp_q),
    .slot_i   (slot),
    .addr_o   (mem_addr_o),
    .data_o   (mem_wdata_o)
  );

  assign sp_wr_o  = done_o;
  assign sp_sel_o = usp_q;
  assign sp_new_o = sp_q - FRAME;

  // R6: new pointer matches the third write's address (lowest byte)
  a_r6_sp_matches_low: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sp_new_o == $past(mem_addr_o, 2)));

  // R5: done is preceded by a write in the cycle before and four cycles before
  a_r5_four_writes: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(mem_we_o, 1) && $past(mem_we_o, 4)));

  // R3: second write sits one byte above the first
  a_r3_shared_above: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o) && !$past(mem_we_o, 2))
      |-> (mem_addr_o == $past(mem_addr_o) + SP_W'(1)));

  // R6: done is a single-cycle pulse with no write after it
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !mem_we_o));

endmodule

// File: tb/test_ctx_save_seq.sv
module test_ctx_save_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [19:0] pc_i;
  logic [15:0] flg_i;
  logic [15:0] isp_i;
  logic [15:0] usp_i;
  logic        sw_int_i;
  logic [5:0]  int_num_i;
  logic        u_sel_i;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_we_o;
  logic        busy_o;
  logic        done_o;
  logic        sp_wr_o;
  logic        sp_sel_o;
  logic [15:0] sp_new_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit wd_hit = 1'b0;

  always #10 clk = ~clk;

  ctx_save_seq i_ctx_save_seq (
    .clk, .rst_n, .start_i, .pc_i, .flg_i, .isp_i, .usp_i,
    .sw_int_i, .int_num_i, .u_sel_i,
    .mem_addr_o, .mem_wdata_o, .mem_we_o, .busy_o, .done_o,
    .sp_wr_o, .sp_sel_o, .sp_new_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; pc_i = '0; flg_i = '0; isp_i = '0; usp_i = '0;
    sw_int_i = 1'b0; int_num_i = '0; u_sel_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_we_o && !done_o && !sp_wr_o && !busy_o, "R1 during reset",
        {mem_we_o, done_o, sp_wr_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mem_we_o && !done_o && !sp_wr_o && !busy_o, "R1 after reset",
        {mem_we_o, done_o, sp_wr_o, busy_o}, 0);
  endtask

  // One full save; disturb raises start and changes inputs mid-save (R8, R11)
  task automatic run_save(input logic [19:0] pc, input logic [15:0] flg,
                          input logic [15:0] isp, input logic [15:0] usp,
                          input bit sw, input logic [5:0] num, input bit us,
                          input bit disturb, input string tag);
    bit          sel;
    logic [15:0] sp;
    logic [15:0] ea [4];
    logic [7:0]  ed [4];
    string       rq [4];
    sel = sw && us && (num >= 6'd32);
    sp  = sel ? usp : isp;
    ea[0] = sp - 16'd2; ed[0] = flg[7:0];                 rq[0] = "R2";
    ea[1] = sp - 16'd1; ed[1] = {flg[15:12], pc[19:16]};  rq[1] = "R3";
    ea[2] = sp - 16'd4; ed[2] = pc[7:0];                  rq[2] = "R4";
    ea[3] = sp - 16'd3; ed[3] = pc[15:8];                 rq[3] = "R4";
    pc_i = pc; flg_i = flg; isp_i = isp; usp_i = usp;
    sw_int_i = sw; int_num_i = num; u_sel_i = us; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(mem_we_o && !done_o, $sformatf("R5 %s we slot %0d", tag, k), mem_we_o, 1);
      chk(mem_addr_o == ea[k], $sformatf("%s %s addr slot %0d", rq[k], tag, k), mem_addr_o, ea[k]);
      chk(mem_wdata_o == ed[k], $sformatf("%s %s data slot %0d", rq[k], tag, k), mem_wdata_o, ed[k]);
      if (disturb) begin
        start_i = 1'b1; pc_i = ~pc; flg_i = ~flg; isp_i = isp + 16'h0100;
        usp_i = usp + 16'h0100; u_sel_i = ~us; sw_int_i = ~sw;
      end
      @(negedge clk);
    end
    chk(done_o && sp_wr_o && !mem_we_o, $sformatf("R6 %s done", tag), {done_o, sp_wr_o, mem_we_o}, 3'b110);
    chk(sp_new_o == sp - 16'd4, $sformatf("R6 %s sp_new", tag), sp_new_o, sp - 16'd4);
    chk(sp_sel_o == sel, $sformatf("R7 %s sp_sel", tag), sp_sel_o, sel);
    @(negedge clk);
    start_i = 1'b0;
    chk(!mem_we_o && !done_o && !busy_o, $sformatf("R8 %s idle after done", tag),
        {mem_we_o, done_o, busy_o}, 0);
  endtask

  task automatic t_basic();
    run_save(20'hA5C3E, 16'h7F21, 16'h4000, 16'h8000, 1'b0, 6'd0, 1'b1, 1'b0, "hw");
  endtask

  task automatic t_user_stack();
    run_save(20'h12345, 16'hC0B4, 16'h4000, 16'h6010, 1'b1, 6'd32, 1'b1, 1'b0, "R7 sw32 user");
    run_save(20'h6789A, 16'h3055, 16'h4000, 16'h6010, 1'b1, 6'd63, 1'b1, 1'b0, "R7 sw63 user");
  endtask

  task automatic t_isp_cases();
    run_save(20'hFEDCB, 16'h1234, 16'h2220, 16'h6010, 1'b1, 6'd31, 1'b1, 1'b0, "R7 sw31 isp");
    run_save(20'h0F0F0, 16'h9001, 16'h2220, 16'h6010, 1'b1, 6'd40, 1'b0, 1'b0, "R7 nouflag isp");
  endtask

  task automatic t_wrap();
    run_save(20'h54321, 16'hA0FF, 16'h0002, 16'h9000, 1'b0, 6'd0, 1'b0, 1'b0, "R9 wrap");
  endtask

  task automatic t_mid_flags();
    run_save(20'h3C3C3, 16'h5066, 16'h1000, 16'h2000, 1'b0, 6'd0, 1'b0, 1'b0, "R10 mid0");
    run_save(20'h3C3C3, 16'h5F66, 16'h1000, 16'h2000, 1'b0, 6'd0, 1'b0, 1'b0, "R10 midF");
  endtask

  task automatic t_disturb();
    run_save(20'hBEEF1, 16'hE2C7, 16'h3456, 16'h789A, 1'b0, 6'd5, 1'b0, 1'b1, "R8 R11 busy start");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_user_stack();
        t_isp_cases();
        t_wrap();
        t_mid_flags();
        t_disturb();
      end
      begin
        repeat (5000) @(negedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule